// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider

This block closes the feedback path of a frequency synthesizer that uses an external dual-modulus prescaler dividing by 64 or 65. It runs on the prescaler's output clock and counts those pulses. It drives the prescaler's modulus-select line so that one full output cycle spans 64·M + S cycles of the prescaler's input. At the start of every output cycle it issues a one-cycle pulse that a phase detector can compare against the reference.

Two down-counters are used. A main counter runs for M prescaler periods. A swallow counter holds the prescaler in its divide-by-65 mode for the first S of those periods. Both counters reload together when the main counter runs out, and that is the only moment the programmed M and S are taken in. Illegal settings are flagged and replaced by a safe fallback, so the counters never stall. A power-down input parks both counters and silences every output.

Top module: `swallow_fb_div`

## Requirements
- R1: For any legal setting (M from 5 to 2047, S from 0 to 63, S < M), consecutive rising edges of `div_pulse_o` are exactly 64·M + S prescaler-input cycles apart.
- R2: `mod_sel_o` (1 = request divide-by-65, 0 = request divide-by-64) is high for exactly the first S `clk_i` cycles of each output cycle, starting with the cycle in which `div_pulse_o` is high. It never goes high when S = 0.
- R3: `div_pulse_o` is high for exactly one `clk_i` cycle, the first cycle of each output cycle, which follows the edge where the main counter expired.
- R4: `main_cnt_i` and `swal_cnt_i` are sampled only on the edge that begins an output cycle. Changing them at any other time leaves the cycle in progress unchanged.
- R5: While `pwr_dn_i` is high at an edge, the following cycle has `div_pulse_o`, `mod_sel_o` and `cfg_err_o` all low. The first edge with `pwr_dn_i` low starts a fresh output cycle, so `div_pulse_o` is high in the cycle after it.
- R6: While `rst_ni` is low at an edge, all outputs are low in the following cycle.
- R7: A main count below 5 raises `cfg_err_o` for that output cycle. The cycle then runs as M = 5, S = 0, which is 320 input cycles.
- R8: A swallow count not below M, with M of at least 5, raises `cfg_err_o` for that output cycle. The cycle then runs with S = 0, which is 64·M input cycles.
- R9: `cfg_err_o` changes only on the edge that starts an output cycle, and it describes the setting sampled there. A legal setting clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Prescaler output clock; one rising edge per prescaler period |
| rst_ni | input | 1 | Synchronous active-low reset |
| pwr_dn_i | input | 1 | Power-down; holds both counters cleared while high |
| main_cnt_i | input | 11 | Main count M from the latched setting |
| swal_cnt_i | input | 6 | Swallow count S from the latched setting |
| mod_sel_o | output | 1 | Modulus request to the prescaler: 1 = divide by 65, 0 = divide by 64 |
| div_pulse_o | output | 1 | One-cycle pulse at the start of each output cycle |
| cfg_err_o | output | 1 | Setting of the current output cycle was out of range |

## Verification
A behavioural prescaler honours `mod_sel_o`, and the bench measures each output cycle in prescaler-input cycles while counting its divide-by-65 periods. The settings cover the smallest legal main count with the largest allowed swallow (5, 4), zero swallow (5, 0) and (20, 0), mid settings, and a large main count with full swallow (1000, 63). A measured total that is off by whole multiples of 64 points to the main counter, while a residual error together with a wrong divide-by-65 tally points to the swallow counter. Every setting is applied right after a cycle starts, so each measured cycle also shows whether the inputs leak into a cycle already running. Illegal settings with a low main count (3, 1) and (0, 0), and with swallow equal to main (7, 7), show whether the fallback and the flag behave. A power-down issued during the divide-by-65 phase shows whether the block parks and restarts cleanly.

// File: rtl/psd_pkg.sv
// Shared constants and types for the pulse-swallow divider.
// Assumes the external prescaler offers exactly two moduli that differ by one.
package psd_pkg;

    parameter int unsigned PSD_MAIN_W_DEF   = 11;
    parameter int unsigned PSD_SWAL_W_DEF   = 6;
    parameter int unsigned PSD_MAIN_MIN_DEF = 5;

    // Modulus request encoding seen by the prescaler.
    typedef enum logic {
        MOD_64 = 1'b0,
        MOD_65 = 1'b1
    } psd_mod_e;

endpackage

// File: rtl/psd_cfg_guard.sv
// Setting guard: checks the main and swallow counts against the legal range.
// It produces the values the counters actually load.
// A main count below MAIN_MIN is raised to MAIN_MIN.
// Any illegal setting runs with a swallow count of zero.
// Assumes MAIN_W > SWAL_W. Purely combinational.
module psd_cfg_guard #(
    parameter int unsigned MAIN_W   = 11,
    parameter int unsigned SWAL_W   = 6,
    parameter int unsigned MAIN_MIN = 5
) (
    input  logic [MAIN_W-1:0] main_i,
    input  logic [SWAL_W-1:0] swal_i,
    output logic [MAIN_W-1:0] main_eff_o,
    output logic [SWAL_W-1:0] swal_eff_o,
    output logic              bad_o
);

    localparam logic [MAIN_W-1:0] MainFloor = MAIN_W'(MAIN_MIN);

    logic [MAIN_W-1:0] swal_ext;
    logic              main_low;
    logic              swal_high;

    // Range classification of the incoming setting.
    always_comb begin
        swal_ext  = MAIN_W'(swal_i);
        main_low  = (main_i < MainFloor);
        swal_high = (swal_ext >= main_i);
        bad_o     = main_low | swal_high;
    end

    // Fallback values that keep the counters cycling.
    always_comb begin
        main_eff_o = main_low ? MainFloor : main_i;
        swal_eff_o = bad_o ? '0 : swal_i;
    end

endmodule

// File: rtl/psd_main_ctr.sv
// Main down-counter: spans M prescaler periods per output cycle.
// When it reaches zero it reloads load_i - 1 and flags expiry.
// Assumes load_i is never below MAIN_MIN, which the setting guard ensures.
module psd_main_ctr #(
    parameter int unsigned MAIN_W   = 11,
    parameter int unsigned MAIN_MIN = 5
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              hold_i,
    input  logic [MAIN_W-1:0] load_i,
    output logic              expire_o,
    output logic [MAIN_W-1:0] count_o
);

    localparam logic [MAIN_W-1:0] One = MAIN_W'(1);

    logic [MAIN_W-1:0] cnt_q;

    // Count down; reload on expiry; clear under reset or power-down.
    always_ff @(posedge clk_i) begin
        if (!rst_ni || hold_i) begin
            cnt_q <= '0;
        end else if (cnt_q == '0) begin
            cnt_q <= load_i - One;
        end else begin
            cnt_q <= cnt_q - One;
        end
    end

    assign expire_o = (cnt_q == '0);
    assign count_o  = cnt_q;

    // R1: between reloads the counter steps down by one per prescaler period.
    a_r1_main_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!hold_i && !expire_o) |=> (count_o == $past(count_o) - One));

    // R7: a reload never starts a cycle shorter than the minimum main count.
    a_r7_reload_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!hold_i && expire_o) |=> (count_o >= MAIN_W'(MAIN_MIN - 1)));

endmodule

// File: rtl/psd_swal_ctr.sv
// Swallow down-counter: loads S at each reload and counts to zero.
// While it is nonzero the prescaler is asked for the larger modulus.
// Assumes reload_i is the main counter's expiry flag.
module psd_swal_ctr #(
    parameter int unsigned SWAL_W = 6
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              hold_i,
    input  logic              reload_i,
    input  logic [SWAL_W-1:0] load_i,
    output logic              active_o,
    output logic [SWAL_W-1:0] count_o
);

    localparam logic [SWAL_W-1:0] One = SWAL_W'(1);

    logic [SWAL_W-1:0] cnt_q;

    // Load at reload, count down to zero and stay there.
    always_ff @(posedge clk_i) begin
        if (!rst_ni || hold_i) begin
            cnt_q <= '0;
        end else if (reload_i) begin
            cnt_q <= load_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - One;
        end
    end

    assign active_o = (cnt_q != '0);
    assign count_o  = cnt_q;

    // R2: the swallow phase shortens by one period per edge.
    a_r2_swal_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!hold_i && !reload_i && active_o) |=> (count_o == $past(count_o) - One));

    // R2: once the swallow phase ends it stays ended until the next reload.
    a_r2_swal_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!hold_i && !reload_i && !active_o) |=> !active_o);

endmodule

// File: rtl/swallow_fb_div.sv
// Pulse-swallow feedback divider top.
// Runs on the prescaler output clock. It steers a 64/65 prescaler so that
// each output cycle lasts 64*M + S prescaler-input cycles.
// Settings are taken only at reload, and illegal ones are flagged and
// replaced by a safe fallback.
// Assumes main_cnt_i and swal_cnt_i are stable around the reload edge.
module swallow_fb_div
    import psd_pkg::*;
#(
    parameter int unsigned MAIN_W   = PSD_MAIN_W_DEF,
    parameter int unsigned SWAL_W   = PSD_SWAL_W_DEF,
    parameter int unsigned MAIN_MIN = PSD_MAIN_MIN_DEF
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              pwr_dn_i,
    input  logic [MAIN_W-1:0] main_cnt_i,
    input  logic [SWAL_W-1:0] swal_cnt_i,
    output logic              mod_sel_o,
    output logic              div_pulse_o,
    output logic              cfg_err_o
);

    logic [MAIN_W-1:0] main_eff;
    logic [SWAL_W-1:0] swal_eff;
    logic              cfg_bad;
    logic              main_exp;
    logic [MAIN_W-1:0] main_cnt;
    logic              swal_act;
    logic [SWAL_W-1:0] swal_cnt;
    logic              div_q;
    logic              err_q;
    psd_mod_e          mod_req;

    psd_cfg_guard #(
        .MAIN_W   (MAIN_W),
        .SWAL_W   (SWAL_W),
        .MAIN_MIN (MAIN_MIN)
    ) u_guard (
        .main_i     (main_cnt_i),
        .swal_i     (swal_cnt_i),
        .main_eff_o (main_eff),
        .swal_eff_o (swal_eff),
        .bad_o      (cfg_bad)
    );

    psd_main_ctr #(
        .MAIN_W   (MAIN_W),
        .MAIN_MIN (MAIN_MIN)
    ) u_main (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .hold_i   (pwr_dn_i),
        .load_i   (main_eff),
        .expire_o (main_exp),
        .count_o  (main_cnt)
    );

    psd_swal_ctr #(
        .SWAL_W (SWAL_W)
    ) u_swal (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .hold_i   (pwr_dn_i),
        .reload_i (main_exp),
        .load_i   (swal_eff),
        .active_o (swal_act),
        .count_o  (swal_cnt)
    );

    // Output pulse and error flag, both captured at the reload edge.
    always_ff @(posedge clk_i) begin
        if (!rst_ni || pwr_dn_i) begin
            div_q <= 1'b0;
            err_q <= 1'b0;
        end else begin
            div_q <= main_exp;
            if (main_exp) begin
                err_q <= cfg_bad;
            end
        end
    end

    // Modulus request follows the swallow phase.
    always_comb begin
        mod_req = swal_act ? MOD_65 : MOD_64;
    end

    assign mod_sel_o   = mod_req;
    assign div_pulse_o = div_q;
    assign cfg_err_o   = err_q;

    // R3: the output pulse never lasts two cycles.
    a_r3_pulse_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        div_pulse_o |=> !div_pulse_o);

    // R5: power-down silences every output in the next cycle.
    a_r5_pd_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pwr_dn_i |=> (!div_pulse_o && !mod_sel_o && !cfg_err_o));

    // R8: the swallow counter never runs past the main counter.
    a_r8_swal_within_main: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (MAIN_W'(swal_cnt) <= main_cnt));

    // R2: at expiry the prescaler is already back on the smaller modulus.
    a_r2_mod_low_at_expiry: assert property (@(posedge clk_i) disable iff (!rst_ni)
        main_exp |-> !mod_sel_o);

    // R9: the error flag only moves at a reload edge.
    a_r9_err_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!main_exp && !pwr_dn_i) |=> $stable(cfg_err_o));

endmodule

// File: tb/test_swallow_fb_div.sv
// Scoreboard bench: a behavioural 64/65 prescaler runs on the 200 MHz clock.
// The driver pushes the expected cycle length, swallow tally and error flag
// for each setting. The monitor measures each output cycle and compares.
`timescale 1ns/1ps
module test_swallow_fb_div;

    typedef struct {
        int    interval;
        int    swal;
        bit    err;
        string tag_ratio;
        string tag_err;
    } exp_t;

    logic        rf_clk = 1'b0;
    logic        rst_n  = 1'b0;
    logic        pwr_dn = 1'b0;
    logic [10:0] main_cnt = 11'd5;
    logic [5:0]  swal_cnt = 6'd4;
    logic        mod_sel;
    logic        div_pulse;
    logic        cfg_err;
    logic        pclk;

    int   pcnt     = 0;
    int   n_tests  = 0;
    int   n_fail   = 0;
    int   wd       = 0;
    bit   mon_en   = 1'b0;
    bit   prev_div = 1'b0;
    bit   have_prev = 1'b0;
    bit   cur_err  = 1'b0;
    int   rf_cnt   = 0;
    int   s_cnt    = 0;
    exp_t sb_q[$];
    exp_t e_pop;
    event rise_ev;

    int cfg_m[10] = '{5, 5, 10, 3, 100, 7, 1000, 0, 20, 9};
    int cfg_s[10] = '{4, 0, 3, 1, 63, 7, 63, 0, 0, 4};

    always #2.5 rf_clk = ~rf_clk;

    // Behavioural prescaler: decides its modulus at the last count.
    always @(posedge rf_clk) begin
        if (pcnt == 64 || (pcnt == 63 && !mod_sel)) pcnt <= 0;
        else pcnt <= pcnt + 1;
    end
    assign pclk = (pcnt < 32);

    swallow_fb_div i_swallow_fb_div (
        .clk_i       (pclk),
        .rst_ni      (rst_n),
        .pwr_dn_i    (pwr_dn),
        .main_cnt_i  (main_cnt),
        .swal_cnt_i  (swal_cnt),
        .mod_sel_o   (mod_sel),
        .div_pulse_o (div_pulse),
        .cfg_err_o   (cfg_err)
    );

    task automatic chk(bit ok, string req, string what, int act, int exp_v);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp_v);
        end
    endtask

    function automatic void push_exp(int m, int s);
        exp_t e;
        bit low = (m < 5);
        bit bad = low || (s >= m);
        int me  = low ? 5 : m;
        int se  = bad ? 0 : s;
        e.interval  = 64 * me + se;
        e.swal      = se;
        e.err       = bad;
        e.tag_ratio = low ? "R7" : (bad ? "R8" : "R1 R4");
        e.tag_err   = low ? "R7" : (bad ? "R8" : "R9");
        sb_q.push_back(e);
    endfunction

    task automatic wait_pclk();
        do @(negedge rf_clk); while (pcnt != 0);
    endtask

    // Monitor: samples once per prescaler period, away from the clock edge.
    always @(negedge rf_clk) begin
        if (mon_en) begin
            rf_cnt++;
            if (pcnt == 0) begin
                if (prev_div) chk(!div_pulse, "R3", "pulse width", int'(div_pulse), 0);
                if (div_pulse && !prev_div) begin
                    if (have_prev) begin
                        if (sb_q.size() == 0) begin
                            chk(1'b0, "R1", "scoreboard empty", 0, 1);
                        end else begin
                            e_pop = sb_q.pop_front();
                            chk(rf_cnt == e_pop.interval, e_pop.tag_ratio, "cycle length",
                                rf_cnt, e_pop.interval);
                            chk(s_cnt == e_pop.swal, "R2", "divide-by-65 periods",
                                s_cnt, e_pop.swal);
                            chk(cur_err == e_pop.err, e_pop.tag_err, "error flag",
                                int'(cur_err), int'(e_pop.err));
                        end
                    end
                    have_prev = 1'b1;
                    rf_cnt    = 0;
                    s_cnt     = 0;
                    cur_err   = cfg_err;
                    -> rise_ev;
                end
                if (mod_sel) s_cnt++;
                prev_div = div_pulse;
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    always @(posedge rf_clk) begin
        wd++;
        if (wd > 190000) begin
            chk(1'b0, "R1", "watchdog expired", wd, 190000);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    // Driver.
    initial begin
        // R6: outputs low while reset is held.
        repeat (4) wait_pclk();
        chk(!div_pulse, "R6", "div_pulse in reset", int'(div_pulse), 0);
        chk(!mod_sel, "R6", "mod_sel in reset", int'(mod_sel), 0);
        chk(!cfg_err, "R6", "cfg_err in reset", int'(cfg_err), 0);

        main_cnt = 11'(cfg_m[0]);
        swal_cnt = 6'(cfg_s[0]);
        push_exp(cfg_m[0], cfg_s[0]);
        mon_en = 1'b1;
        rst_n  = 1'b1;

        // R4: each new setting is applied while the previous one is running.
        for (int i = 1; i < 10; i++) begin
            @(rise_ev);
            main_cnt = 11'(cfg_m[i]);
            swal_cnt = 6'(cfg_s[i]);
            push_exp(cfg_m[i], cfg_s[i]);
        end
        @(rise_ev);
        @(rise_ev);
        mon_en = 1'b0;
        chk(sb_q.size() == 0, "R1", "scoreboard drained", sb_q.size(), 0);

        // R5: power-down issued during the divide-by-65 phase.
        pwr_dn = 1'b1;
        for (int k = 0; k < 3; k++) begin
            wait_pclk();
            chk(!div_pulse, "R5", "div_pulse in power-down", int'(div_pulse), 0);
            chk(!mod_sel, "R5", "mod_sel in power-down", int'(mod_sel), 0);
            chk(!cfg_err, "R5", "cfg_err in power-down", int'(cfg_err), 0);
        end
        pwr_dn = 1'b0;
        wait_pclk();
        chk(div_pulse, "R5", "pulse after wake-up", int'(div_pulse), 1);
        chk(mod_sel, "R2", "swallow phase after wake-up", int'(mod_sel), 1);
        wait_pclk();
        chk(!div_pulse, "R3", "pulse width after wake-up", int'(div_pulse), 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule